// File: doc/BRIEF.md
# RTC Time and Alarm Register File

This block is the software-visible core of a real-time clock. It keeps a 32-bit count of seconds, advanced by a one-second pulse that an external prescaler delivers. It also holds an alarm compare value, a calibration word for the prescaler, two control bits, and a small interrupt controller. Software reaches all of it through a single-cycle 32-bit register port.

Setting the time is deferred. A value written to the set-time register is held aside and can be read back at once. It replaces the running count only at the next one-second pulse. Software reads the set-time readback register until the seconds status bit shows that a pulse has happened, and reads the current-time register after that.

There are two interrupt lines, one for seconds and one for the alarm. Each line is gated by an enable bit. The enable bits are set through one write-one register and cleared through another.

Top module: `rtc_regfile`

## Requirements
- R1: After reset, every readable register returns zero, and both interrupt outputs are low.
- R2: A write to offset 0x00 does not change the current time at offset 0x10 until a one-second pulse arrives. Offset 0x04 returns the last value written to 0x00.
- R3: A pulse that arrives while a set-time value is pending loads that value as the current time. Later pulses increment from it.
- R4: A pulse with nothing pending adds one to the current time, and 0xFFFFFFFF wraps to 0.
- R5: Interrupt status is read at offset 0x20. Bit 0 sets on every pulse. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: Status bit 1 sets on the pulse that makes the current time equal the alarm value. The alarm value is written and read at offset 0x18.
- R7: When a pulse and a write-1-to-clear of its status bit land in the same cycle, the bit stays set.
- R8: Writing 1 to a bit of offset 0x28 sets that enable bit, and writing 1 to a bit of offset 0x2C clears it. Zero bits have no effect in either register. Offset 0x24 returns the enable bits in bits [1:0]: bit 0 is seconds, bit 1 is alarm.
- R9: The seconds output is high while status bit 0 and enable bit 0 are both set. The alarm output is high while status bit 1 and enable bit 1 are both set. Status bits set even while their interrupt is disabled.
- R10: Only the low 21 bits of a write to offset 0x08 are stored. They are read back at offset 0x0C with bits 31:21 zero.
- R11: At offset 0x40, control bits 31 and 24 are read/write, and all other bits read zero.
- R12: Offset 0x14 returns the prescaler tick input. The write-only offsets 0x00, 0x08, 0x28 and 0x2C read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_pulse | input | 1 | One-cycle one-second event from the prescaler |
| tick_val | input | 16 | Prescaler tick count, readable at 0x14 |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| calib_out | output | 21 | Stored calibration word for the prescaler |
| osc_en | output | 1 | Oscillator enable (control bit 24) |
| batt_en | output | 1 | Battery-switch enable (control bit 31) |
| irq_sec | output | 1 | Seconds interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
A stuck pending flag shows up at offset 0x10 on the pulse after a time write, in one of two ways: the loaded value is missing, or the value is loaded a second time instead of being incremented. Either shows up within one pulse. A bad status or enable bit shows up on the interrupt line in the same cycle, because the outputs have no register after the AND. A wrong alarm comparison shows up on the exact pulse where the time is meant to match, so the bench steps the time through the alarm value one pulse at a time.

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int ADDR_W = 8,
  parameter int CAL_W  = 21,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_pulse,
  input  logic [TICK_W-1:0] tick_val,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [CAL_W-1:0]  calib_out,
  output logic              osc_en,
  output logic              batt_en,
  output logic              irq_sec,
  output logic              irq_alarm
);
  localparam logic [ADDR_W-1:0] A_SETW = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_SETR = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_CALW = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_CALR = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_TICK = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_ALRM = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h40);

  logic [31:0]      cur_time, set_time, alarm_val;
  logic             pend;
  logic [CAL_W-1:0] calib;
  logic [1:0]       sts, ien;
  logic             ctl_batt, ctl_osc;

  wire        wr_set  = wr_en && addr == A_SETW;
  wire [31:0] next_tm = pend ? set_time : cur_time + 32'd1;
  wire        hit     = sec_pulse && next_tm == alarm_val;
  wire [1:0]  clr     = (wr_en && addr == A_STS) ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_time  <= '0;
      set_time  <= '0;
      pend      <= 1'b0;
      alarm_val <= '0;
      calib     <= '0;
      sts       <= '0;
      ien       <= '0;
      ctl_batt  <= 1'b0;
      ctl_osc   <= 1'b0;
    end else begin
      if (sec_pulse) cur_time <= next_tm;
      if (wr_set) begin
        set_time <= wdata;
        pend     <= 1'b1;
      end else if (sec_pulse) begin
        pend <= 1'b0;
      end
      sts <= (sts & ~clr) | {hit, sec_pulse};
      if (wr_en) begin
        case (addr)
          A_ALRM: alarm_val <= wdata;
          A_CALW: calib     <= wdata[CAL_W-1:0];
          A_EN:   ien       <= ien | wdata[1:0];
          A_DIS:  ien       <= ien & ~wdata[1:0];
          A_CTRL: begin
            ctl_batt <= wdata[31];
            ctl_osc  <= wdata[24];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_SETR:  rdata = set_time;
      A_CALR:  rdata = {{(32-CAL_W){1'b0}}, calib};
      A_CUR:   rdata = cur_time;
      A_TICK:  rdata = {{(32-TICK_W){1'b0}}, tick_val};
      A_ALRM:  rdata = alarm_val;
      A_STS:   rdata = {30'd0, sts};
      A_MASK:  rdata = {30'd0, ien};
      A_CTRL:  rdata = {ctl_batt, 6'd0, ctl_osc, 24'd0};
      default: rdata = '0;
    endcase
  end

  assign calib_out = calib;
  assign osc_en    = ctl_osc;
  assign batt_en   = ctl_batt;
  assign irq_sec   = sts[0] & ien[0];
  assign irq_alarm = sts[1] & ien[1];

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !sec_pulse |=> $stable(cur_time)); // R2
  AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rst_n) sec_pulse && pend |=> cur_time == $past(set_time)); // R3
  AST_TIME_INC: assert property (@(posedge clk) disable iff (!rst_n) sec_pulse && !pend |=> cur_time == $past(cur_time) + 32'd1); // R4
  AST_SEC_WINS: assert property (@(posedge clk) disable iff (!rst_n) sec_pulse |=> sts[0]); // R7
  AST_ALARM_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $rose(sts[1]) && !$past(wr_en) |-> cur_time == alarm_val); // R6
  AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(ien)); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !ien[1] |-> !irq_alarm); // R9
endmodule

// File: tb/rtc_regfile_bench.sv
`timescale 1ns/1ps
module rtc_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_pulse = 1'b0;
  logic [15:0] tick_val = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [20:0] calib_out;
  logic        osc_en, batt_en, irq_sec, irq_alarm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  rtc_regfile u_rtc_regfile (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .tick_val(tick_val),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .calib_out(calib_out), .osc_en(osc_en), .batt_en(batt_en),
    .irq_sec(irq_sec), .irq_alarm(irq_alarm)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sec_pulse = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
  endtask

  task automatic wr_pulse(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sec_pulse = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
  endtask

  task automatic pulse();
    @(negedge clk);
    sec_pulse = 1'b1; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    sec_pulse = 1'b0; wr_en = 1'b0; addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic irq(input logic [1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    sec_pulse = 1'b0; wr_en = 1'b0;
    it.is_irq = 1'b1; it.exp = {30'd0, e}; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = q.pop_front();
        got = it.is_irq ? {30'd0, irq_alarm, irq_sec} : rdata;
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s got %h exp %h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h10, 32'd0, "R1 time");
    rd(8'h20, 32'd0, "R1 status");
    rd(8'h24, 32'd0, "R1 mask");
    rd(8'h40, 32'd0, "R1 ctrl");
    irq(2'b00, "R1 irq");
    pulse(); pulse(); pulse();
    rd(8'h10, 32'd3, "R4 increment");
    rd(8'h20, 32'd1, "R5 sec status");
    irq(2'b00, "R9 status set while disabled");
    wr(8'h20, 32'd0);
    rd(8'h20, 32'd1, "R5 write zero no effect");
    wr(8'h20, 32'd1);
    rd(8'h20, 32'd0, "R5 w1c");
    wr(8'h00, 32'd100);
    rd(8'h10, 32'd3, "R2 time held");
    rd(8'h04, 32'd100, "R2 readback");
    pulse();
    rd(8'h10, 32'd100, "R3 load");
    pulse();
    rd(8'h10, 32'd101, "R3 increment after load");
    wr(8'h28, 32'd2);
    rd(8'h24, 32'd2, "R8 enable alarm");
    wr(8'h28, 32'd0);
    wr(8'h2C, 32'd0);
    rd(8'h24, 32'd2, "R8 zeros no effect");
    wr(8'h28, 32'd1);
    rd(8'h24, 32'd3, "R8 enable both");
    irq(2'b01, "R9 sec irq");
    wr(8'h20, 32'd3);
    irq(2'b00, "R9 cleared");
    wr(8'h18, 32'd103);
    rd(8'h18, 32'd103, "R6 alarm readback");
    pulse();
    rd(8'h20, 32'd1, "R6 no early alarm");
    pulse();
    rd(8'h20, 32'd3, "R6 alarm match");
    irq(2'b11, "R9 both irq");
    wr(8'h2C, 32'd2);
    irq(2'b01, "R8 disable alarm irq");
    rd(8'h24, 32'd1, "R8 mask after disable");
    wr_pulse(8'h20, 32'd1);
    rd(8'h20, 32'd3, "R7 event wins");
    rd(8'h10, 32'd104, "R7 time");
    wr(8'h20, 32'd3);
    wr(8'h00, 32'hFFFF_FFFF);
    pulse();
    rd(8'h10, 32'hFFFF_FFFF, "R3 load max");
    pulse();
    rd(8'h10, 32'd0, "R4 wrap");
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h001F_FFFF, "R10 calib width");
    rd(8'h08, 32'd0, "R12 calib write reads zero");
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, 32'h8100_0000, "R11 ctrl bits");
    wr(8'h40, 32'd0);
    rd(8'h40, 32'd0, "R11 ctrl clear");
    tick_val = 16'h1234;
    rd(8'h14, 32'h0000_1234, "R12 tick");
    rd(8'h28, 32'd0, "R12 enable reads zero");
    rd(8'h00, 32'd0, "R12 set write reads zero");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule